// File: doc/BRIEF.md
# Fractional Reference Clock Generator

This block derives a slower reference clock from one of up to sixteen input sources. The division ratio has an integer part and a fractional part with a resolution of 1/512, so the output frequency is the selected input frequency divided by 2·(div + trim/512). When the integer and the fraction are both zero, the selected input passes straight through. Software controls the block through a small register port. Each register has a plain write alias, a bit-set alias and a bit-clear alias.

The source inputs are sampled on the block clock. Each rising edge of the selected source counts as one input cycle, so the block clock must run at least twice as fast as any source. The fraction comes from a 9-bit phase accumulator. At the start of every half-period the trim value is added to the accumulator. A carry out of the accumulator makes that half-period one input cycle longer. New divisor values are staged in the registers and reach the working divider only through a divider-switch request, which the hardware clears itself. The source select is frozen while the generator is active.

There is no streaming data path. The register port is a plain single-cycle write strobe with a combinational read, so it has no back-pressure.

Top module: `refclk_gen`

## Requirements
- R1: After reset, both registers read 0, the clock output and the output-enable pin are low, and the active flag reads 0.
- R2: Byte offset 0x00 is the control register, 0x04 sets the written bits and 0x08 clears them. The trim register sits at 0x10, 0x14 and 0x18 in the same way. Control fields are: select at [3:0], active at [8] (read-only), divider switch at [9], output enable at [12], on at [15], and integer divisor at [30:16]. Trim is at [31:23]. Every other bit reads 0.
- R3: With trim 0 and divisor N>0, every half-period of the output lasts exactly N rising edges of the selected input.
- R4: With a nonzero trim, each half-period first adds trim into a 9-bit accumulator. The accumulator is cleared at start and on every load. A carry out of the accumulator lengthens that half-period from N to N+1 input edges, and a half-period is never shorter than one edge.
- R5: With divisor 0 and trim 0, the clock output follows the selected input, delayed by two block-clock cycles.
- R6: Divisor and trim values written without a divider-switch request do not change the output. Writing 1 to bit 9 sets the request, and the bit reads 1 until the transfer is done. The transfer happens on the next clock while stopped, or at the next half-period boundary while running. The bit then clears itself and the new values apply from the next half-period.
- R7: A write to the select field while the active flag is 1 is ignored.
- R8: The active flag reads 1 from the cycle after on is set. After on is cleared, it stays 1 until the output has finished its current half-period and is low. From then on the output stays low.
- R9: The clock output pin is held low while output enable is 0, even though the generator runs. The output-enable pin mirrors bit 12.
- R10: The select field value s picks input src_i[s] as the clock source, and the other inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all sources are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Candidate source clocks |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ref_clk_o | output | 1 | Divided reference clock, gated by output enable |
| ref_oe_o | output | 1 | Output-enable level for the pad |

## Verification
The bench builds the block with its defaults: sixteen sources, a 15-bit divisor and a 9-bit trim. The sources run four block clocks per period, so divisors 1 to 5 give hundreds of half-periods within a short run. Trim values of 256, 100 and 511 drive the accumulator through regular, irregular and nearly-every-time carries. Trim 511 also wraps the accumulator on almost every step. A scoreboard measures each half-period in input edges and compares it against a model of the accumulator sequence. Mid-run divider switches, stop timing and the select freeze are also checked.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int REG_DW   = 32;
  localparam int ADDR_W   = 5;
  localparam int SEL_W    = 4;
  localparam int DIV_W    = 15;
  localparam int TRIM_W   = 9;
  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int ON_BIT   = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_LSB = REG_DW - TRIM_W;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  function automatic logic [REG_DW-1:0] apply_access(acc_kind_e k,
                                                     logic [REG_DW-1:0] cur,
                                                     logic [REG_DW-1:0] wd);
    case (k)
      ACC_WRITE: return wd;
      ACC_SET:   return cur | wd;
      ACC_CLEAR: return cur & ~wd;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs import refclk_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              active_i,
  input  logic              ack_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              oe_o,
  output logic              on_o,
  output logic              sw_req_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TRIM_W-1:0] trim_o
);
  logic [SEL_W-1:0]  sel_q;
  logic              oe_q, on_q, sw_q;
  logic [DIV_W-1:0]  div_q;
  logic [TRIM_W-1:0] trim_q;
  logic [REG_DW-1:0] ctrl_img, trim_img, ctrl_new, trim_new;
  acc_kind_e         kind;
  logic              hit_ctrl, hit_trim, sw_set;

  always_comb begin
    ctrl_img = '0;
    ctrl_img[SEL_LSB +: SEL_W] = sel_q;
    ctrl_img[ACT_BIT]          = active_i;
    ctrl_img[SW_BIT]           = sw_q;
    ctrl_img[OE_BIT]           = oe_q;
    ctrl_img[ON_BIT]           = on_q;
    ctrl_img[DIV_LSB +: DIV_W] = div_q;
    trim_img = '0;
    trim_img[TRIM_LSB +: TRIM_W] = trim_q;
    kind     = acc_kind_e'(addr_i[3:2]);
    hit_ctrl = we_i && !addr_i[4] && (kind != ACC_NONE);
    hit_trim = we_i &&  addr_i[4] && (kind != ACC_NONE);
    ctrl_new = apply_access(kind, ctrl_img, wdata_i);
    trim_new = apply_access(kind, trim_img, wdata_i);
    sw_set   = hit_ctrl && (kind != ACC_CLEAR) && wdata_i[SW_BIT];
    rdata_o  = addr_i[4] ? trim_img : ctrl_img;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      oe_q   <= 1'b0;
      on_q   <= 1'b0;
      sw_q   <= 1'b0;
      div_q  <= '0;
      trim_q <= '0;
    end else begin
      if (hit_ctrl) begin
        if (!active_i) sel_q <= ctrl_new[SEL_LSB +: SEL_W];
        oe_q  <= ctrl_new[OE_BIT];
        on_q  <= ctrl_new[ON_BIT];
        div_q <= ctrl_new[DIV_LSB +: DIV_W];
      end
      if (hit_trim) trim_q <= trim_new[TRIM_LSB +: TRIM_W];
      sw_q <= (sw_q && !ack_i) || sw_set;
    end
  end

  assign sel_o    = sel_q;
  assign oe_o     = oe_q;
  assign on_o     = on_q;
  assign sw_req_o = sw_q;
  assign div_o    = div_q;
  assign trim_o   = trim_q;

  // R7: source select cannot move while the generator is active
  a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> $stable(sel_q));
  // R6: the switch request only drops after the divider took the values
  a_r6_sw_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_q) |-> $past(ack_i));
endmodule

// File: rtl/refclk_src_pick.sv
module refclk_src_pick import refclk_pkg::*; #(
  parameter int NSRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             lvl_o,
  output logic             tick_o
);
  localparam int NPAD = 1 << SEL_W;
  logic [NPAD-1:0] pad;
  logic            lvl_q, prev_q;

  generate
    if (NSRC >= NPAD) begin : g_full
      assign pad = src_i[NPAD-1:0];
    end else begin : g_short
      assign pad = {{(NPAD-NSRC){1'b0}}, src_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= pad[sel_i];
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign tick_o = lvl_q && !prev_q;

  // R10: one input edge yields a single one-cycle tick
  a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div import refclk_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_i,
  input  logic              tick_i,
  input  logic              lvl_i,
  input  logic              load_req_i,
  input  logic [DIV_W-1:0]  new_div_i,
  input  logic [TRIM_W-1:0] new_trim_i,
  output logic              load_ack_o,
  output logic              run_o,
  output logic              out_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0]  w_div, n_div;
  logic [TRIM_W-1:0] w_trim, n_trim, acc_q, base;
  logic [TRIM_W:0]   sum;
  logic [CNT_W-1:0]  cnt_q, len_q, n_len;
  logic              run_q, out_q;
  logic              bypass, boundary, take_new, carry, n_bypass;

  always_comb begin
    bypass   = (w_div == '0) && (w_trim == '0);
    boundary = run_q && tick_i && (bypass || (cnt_q + 1'b1 == len_q));
    take_new = load_req_i && (boundary || !run_q);
    n_div    = take_new ? new_div_i  : w_div;
    n_trim   = take_new ? new_trim_i : w_trim;
    base     = (take_new || !run_q) ? '0 : acc_q;
    sum      = {1'b0, base} + {1'b0, n_trim};
    carry    = sum[TRIM_W];
    n_len    = {1'b0, n_div} + {{DIV_W{1'b0}}, carry};
    if (n_len == '0) n_len = {{DIV_W{1'b0}}, 1'b1};
    n_bypass = (n_div == '0) && (n_trim == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_div  <= '0;
      w_trim <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      run_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (take_new) begin
        w_div  <= new_div_i;
        w_trim <= new_trim_i;
      end
      if (!run_q) begin
        out_q <= 1'b0;
        cnt_q <= '0;
        if (on_i) begin
          run_q <= 1'b1;
          acc_q <= sum[TRIM_W-1:0];
          len_q <= n_len;
        end else begin
          acc_q <= '0;
        end
      end else if (bypass) begin
        if (!on_i && !lvl_i) begin
          run_q <= 1'b0;
          out_q <= 1'b0;
        end else begin
          out_q <= lvl_i;
          if (take_new) begin
            cnt_q <= '0;
            acc_q <= sum[TRIM_W-1:0];
            len_q <= n_len;
            if (!n_bypass) out_q <= 1'b0;
          end
        end
      end else if (boundary) begin
        cnt_q <= '0;
        acc_q <= sum[TRIM_W-1:0];
        len_q <= n_len;
        if (!on_i) begin
          run_q <= 1'b0;
          out_q <= 1'b0;
        end else begin
          out_q <= !out_q;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_ack_o = take_new;
  assign run_o      = run_q;
  assign out_o      = out_q;

  // R3: the edge counter never passes the half-period length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass) |-> (cnt_q < len_q));
  // R4: a half-period spans div or div+1 edges, never zero
  a_r4_len_span: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bypass) |-> ((len_q >= {1'b0, w_div}) && (len_q <= {1'b0, w_div} + 1'b1) && (len_q != '0)));
  // R8: the generator stops only after on was cleared, with the output low
  a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (!out_q && !$past(on_i)));
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen import refclk_pkg::*; #(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              ref_clk_o,
  output logic              ref_oe_o
);
  logic [SEL_W-1:0]  sel;
  logic [DIV_W-1:0]  div;
  logic [TRIM_W-1:0] trim;
  logic              oe, on, sw_req, ack, run, out, lvl, tick, active;

  assign active = on | run;

  refclk_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .active_i (active),
    .ack_i    (ack),
    .sel_o    (sel),
    .oe_o     (oe),
    .on_o     (on),
    .sw_req_o (sw_req),
    .div_o    (div),
    .trim_o   (trim)
  );

  refclk_src_pick #(.NSRC(NSRC)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .sel_i  (sel),
    .lvl_o  (lvl),
    .tick_o (tick)
  );

  refclk_frac_div u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_i       (on),
    .tick_i     (tick),
    .lvl_i      (lvl),
    .load_req_i (sw_req),
    .new_div_i  (div),
    .new_trim_i (trim),
    .load_ack_o (ack),
    .run_o      (run),
    .out_o      (out)
  );

  assign ref_clk_o = out & oe;
  assign ref_oe_o  = oe;
endmodule

// File: tb/tb_refclk_gen.sv
module tb_refclk_gen;
  localparam int CLK_P = 10;
  localparam int NSRC  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  src = '0;
  logic             we = 1'b0;
  logic [4:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             ref_clk, ref_oe;

  always #(CLK_P/2) clk = ~clk;

  refclk_gen #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .ref_clk_o(ref_clk), .ref_oe_o(ref_oe)
  );

  int    checks = 0, errors = 0;
  int    exp_q[$];
  int    skip = 0, rises = 0, last_rise = 0, tog_cnt = 0, ph = 0, gen_sel = 0;
  bit    mon_en = 0, gen_en = 0;
  logic  last_out = 1'b0, lvl = 1'b0;
  logic [2:0] hist = '0;
  string cur_req = "R1";

  function automatic void check_int(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  // monitor first, then source driver, at every falling edge
  always @(negedge clk) begin
    int e;
    if (ref_clk !== last_out) begin
      tog_cnt++;
      if (mon_en) begin
        if (skip > 0) skip--;
        else if (exp_q.size() == 0) check_int(cur_req, "unexpected half-period", rises - last_rise, 0);
        else begin
          e = exp_q.pop_front();
          check_int(cur_req, "half-period edges", rises - last_rise, e);
        end
      end
      last_rise = rises;
      last_out  = ref_clk;
    end
    if (gen_en) begin
      ph++;
      if (ph >= 2) begin
        ph = 0;
        lvl = ~lvl;
        src[gen_sel] = lvl;
        if (lvl) rises++;
      end
    end
    hist = {hist[1:0], lvl};
  end

  function automatic logic [31:0] ctrl_word(int dv, bit on, bit oe, bit sw, int sel);
    return (32'(dv) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel);
  endfunction

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // driver side of the scoreboard: model of the trim accumulator
  task automatic push_seq(int dv, int tr, int first, int n);
    int acc = 0;
    for (int i = 0; i < first + n; i++) begin
      int s, c, l;
      s = acc + tr; c = (s >= 512) ? 1 : 0; acc = s % 512;
      l = dv + c; if (l == 0) l = 1;
      if (i >= first) exp_q.push_back(l);
    end
  endtask

  task automatic wait_toggle();
    int t = tog_cnt;
    while (tog_cnt == t) begin @(negedge clk); #1; end
  endtask

  task automatic drain(string req);
    int k = 0;
    while (exp_q.size() != 0 && k < 4000) begin @(negedge clk); #1; k++; end
    mon_en = 0;
    check_int(req, "half-periods left unchecked", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic start_run(int dv, int tr, int sel, int n, string req);
    cur_req = req;
    reg_wr(5'h10, 32'(tr) << 23);
    reg_wr(5'h00, ctrl_word(dv, 0, 1, 1, sel));
    repeat (2) @(negedge clk);
    exp_q.delete(); push_seq(dv, tr, 1, n); skip = 1; mon_en = 1;
    reg_wr(5'h04, 32'h0000_8000);
  endtask

  task automatic stop_run(string req);
    logic [31:0] d;
    int k = 0;
    mon_en = 0;
    reg_wr(5'h08, 32'h0000_8000);
    reg_rd(5'h00, d);
    while (d[8] && k < 3000) begin @(negedge clk); reg_rd(5'h00, d); k++; end
    check_int(req, "active flag after stop", d[8], 0);
    check_int(req, "output level after stop", ref_clk, 0);
  endtask

  task automatic run_case(int dv, int tr, int n, string req);
    start_run(dv, tr, 0, n, req);
    drain(req);
    stop_run(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(5'h00, d); check_int("R1", "control after reset", d, 0);
    reg_rd(5'h10, d); check_int("R1", "trim after reset", d, 0);
    check_int("R1", "clock pin after reset", ref_clk, 0);
    check_int("R1", "oe pin after reset", ref_oe, 0);
    gen_en = 1;

    // R2 register map and aliases
    reg_wr(5'h10, 32'hFFFF_FFFF);
    reg_rd(5'h10, d); check_int("R2", "trim field only", d, 32'hFF80_0000);
    reg_wr(5'h00, 32'hFFFF_7FFF);
    reg_rd(5'h00, d); check_int("R2", "control image with pending switch", d, 32'h7FFF_120F);
    @(negedge clk);
    reg_rd(5'h00, d); check_int("R6", "switch bit cleared while stopped", d, 32'h7FFF_100F);
    reg_wr(5'h08, 32'h0000_1000);
    reg_rd(5'h00, d); check_int("R2", "clear alias on oe", d, 32'h7FFF_000F);
    check_int("R9", "oe pin mirrors bit", ref_oe, 0);
    reg_wr(5'h04, 32'h0000_1000);
    reg_rd(5'h00, d); check_int("R2", "set alias on oe", d, 32'h7FFF_100F);
    reg_wr(5'h18, 32'h0080_0000);
    reg_rd(5'h10, d); check_int("R2", "trim clear alias", d, 32'hFF00_0000);
    reg_wr(5'h00, 32'h0);
    reg_wr(5'h10, 32'h0);

    // R3 integer division
    run_case(3, 0, 8, "R3");
    run_case(1, 0, 8, "R3");

    // R4 fractional trim
    run_case(2, 256, 10, "R4");
    run_case(1, 511, 12, "R4");
    run_case(3, 100, 12, "R4");

    // R6 staged values and mid-run switch
    start_run(3, 0, 0, 4, "R6");
    drain("R6");
    wait_toggle();
    reg_wr(5'h00, ctrl_word(5, 1, 1, 0, 0));
    cur_req = "R6"; push_seq(3, 0, 0, 6); skip = 0; mon_en = 1;
    drain("R6");
    wait_toggle();
    reg_wr(5'h00, ctrl_word(5, 1, 1, 1, 0));
    reg_rd(5'h00, d); check_int("R6", "switch bit pending while running", d[9], 1);
    push_seq(5, 0, 0, 6); skip = 1; mon_en = 1;
    drain("R6");
    reg_rd(5'h00, d); check_int("R6", "switch bit cleared after transfer", d[9], 0);

    // R7 select frozen while active
    wait_toggle();
    reg_wr(5'h00, ctrl_word(5, 1, 1, 0, 1));
    reg_rd(5'h00, d); check_int("R7", "select while active", d[3:0], 0);
    cur_req = "R7"; push_seq(5, 0, 0, 4); skip = 0; mon_en = 1;
    drain("R7");

    // R8 active window and stop timing
    mon_en = 0;
    t = 0;
    while (t == 0) begin wait_toggle(); if (ref_clk) t = 1; end
    reg_wr(5'h08, 32'h0000_8000);
    reg_rd(5'h00, d);
    check_int("R8", "active right after on cleared", d[8], 1);
    check_int("R8", "output still high mid half-period", ref_clk, 1);
    k = 0;
    while (d[8] && k < 200) begin @(negedge clk); reg_rd(5'h00, d); k++; end
    check_int("R8", "active dropped within one half-period", d[8], 0);
    check_int("R8", "output low when stopped", ref_clk, 0);
    t = tog_cnt;
    repeat (60) @(negedge clk);
    check_int("R8", "no edges after stop", tog_cnt - t, 0);
    reg_wr(5'h04, 32'h0000_8000);
    reg_rd(5'h00, d); check_int("R8", "active after on set", d[8], 1);
    stop_run("R8");

    // R5 bypass
    reg_wr(5'h10, 32'h0);
    reg_wr(5'h00, ctrl_word(0, 1, 1, 1, 0));
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      check_int("R5", "bypass follows input", ref_clk, hist[2]);
    end
    stop_run("R5");

    // R9 output enable gating
    reg_wr(5'h00, ctrl_word(1, 1, 0, 1, 0));
    t = tog_cnt;
    repeat (40) @(negedge clk);
    check_int("R9", "pin edges with oe low", tog_cnt - t, 0);
    check_int("R9", "oe pin low", ref_oe, 0);
    reg_rd(5'h00, d); check_int("R9", "generator active behind gate", d[8], 1);
    reg_wr(5'h04, 32'h0000_1000);
    t = tog_cnt;
    repeat (30) @(negedge clk);
    check_int("R9", "pin toggles after oe set", (tog_cnt > t) ? 1 : 0, 1);
    check_int("R9", "oe pin high", ref_oe, 1);
    stop_run("R9");

    // R10 source selection
    gen_en = 0; @(negedge clk);
    src = '0; lvl = 1'b0; ph = 0; gen_sel = 2; gen_en = 1;
    start_run(2, 0, 2, 6, "R10");
    drain("R10");
    stop_run("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule